// File: doc/BRIEF.md
# Memory-Sequence Game Controller

This block runs a repeat-after-me memory game built around four direction buttons and one centre button. After the centre button is pressed it shows a sequence of four-way patterns, one at a time. It then expects the player to press the same directions in the same order. Each correct round raises the level by one, and the level is the length of the sequence. A wrong press ends the game. A message code and its blink flags tell a separate display driver what to show between rounds: begin, pass, fail or end. The level is given as two decimal digits and the pattern being shown as a two-bit code.

The controller stores no sequence. An external pattern source is reseeded from the same seed before every show pass and before every entry pass, so it yields the same stream each time. The controller takes a pattern only while the source flags `pat_ready`, and it pulses `pat_next` to advance the source. The time for which each pattern is shown comes from two difficulty switches, which are latched when a game starts. Every duration is a tick-count parameter, so a simulation can use small values while hardware uses real seconds.

Top module: `memseq_ctrl`

## Requirements
- R1: After reset the controller is idle: `msg_code` = 1 (begin) with `msg_blink` = 1 and `msg_on` = 1, level digits read 0 and 1, and `show_valid` = 0.
- R2: In the idle state a rising edge on `ctr_btn` starts a game. It latches `diff_sw`, sets the level to 1 and starts a show pass that presents `level` patterns.
- R3: Each shown pattern stays on `show_valid`/`show_pat` for (4 - `diff_sw`) x `DELAY_UNIT` cycles (00 = 4 units, 01 = 3, 10 = 2, 11 = 1). The next pattern follows after at least one cycle with `show_valid` low. A change of `diff_sw` during a game has no effect.
- R4: `pat_reseed` pulses once before each show pass and once before each entry pass. A pattern is taken only in a cycle with `pat_ready` high, and `pat_next` pulses exactly in that cycle. While `pat_ready` is low, nothing is shown.
- R5: `dir_pulse` bit 0 is up (code 0), bit 1 right (code 1), bit 2 left (code 2) and bit 3 down (code 3). During entry, a press matches only if its vector is the one-hot bit for the expected code. Presses outside the entry phase are ignored.
- R6: When every press of a round matches, `msg_code` = 2 (pass) is shown steadily for `MSG_TICKS` cycles. The level then rises by one and a new show pass starts.
- R7: The first mismatching press shows `msg_code` = 3 (fail) steadily for `MSG_TICKS` cycles, after which the game ends.
- R8: At game end, `msg_code` = 4 (end) blinks for `MSG_TICKS` cycles, then the controller returns to idle. Clearing level `MAX_LEVEL` leads to the end message and not to a further level.
- R9: Holding `ctr_btn` high for `HOLD_TICKS` consecutive cycles returns the controller to idle from any state. A shorter hold changes nothing.
- R10: A blinking message is lit for `BLINK_TICKS` cycles and then dark for `BLINK_TICKS` cycles, starting lit when its state is entered.
- R11: `lvl_tens`/`lvl_ones` always hold the current level as two BCD digits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctr_btn | input | 1 | Debounced centre button level |
| dir_pulse | input | 4 | One-cycle debounced direction presses (up, right, left, down) |
| diff_sw | input | 2 | Difficulty switches |
| pat_ready | input | 1 | Pattern source has a valid code |
| pat_code | input | 2 | Current pattern code from the source |
| pat_reseed | output | 1 | Reload the pattern source from its seed |
| pat_next | output | 1 | Advance the pattern source |
| msg_code | output | 3 | 0 none, 1 begin, 2 pass, 3 fail, 4 end |
| msg_blink | output | 1 | Current message is a blinking one |
| msg_on | output | 1 | Message should be lit in this cycle |
| lvl_tens | output | 4 | Level, tens digit (BCD) |
| lvl_ones | output | 4 | Level, ones digit (BCD) |
| show_valid | output | 1 | A pattern is being shown |
| show_pat | output | 2 | Code of the pattern being shown |

## Verification
The bench builds the controller with MSG_TICKS = 20, DELAY_UNIT = 3, BLINK_TICKS = 4, HOLD_TICKS = 30 and MAX_LEVEL = 11. With these values all four difficulty delays can be measured exactly as 12, 9, 6 and 3 cycles. A complete game to the final level fits in a few thousand cycles, and the tens digit carries at level 10. The short blink period lets several lit and dark phases occur inside one end message. The hold threshold is long enough to separate an ignored short hold from an aborting long one.

// File: rtl/memseq_pkg.sv
package memseq_pkg;

   typedef enum logic [3:0] {
      ST_IDLE,
      ST_SEED_SHOW,
      ST_SHOW_FETCH,
      ST_SHOW_HOLD,
      ST_SEED_ENTRY,
      ST_ENTRY_FETCH,
      ST_ENTRY_GET,
      ST_PASS,
      ST_FAIL,
      ST_OVER
   } game_st_t;

   typedef enum logic [2:0] {
      MSG_NONE  = 3'd0,
      MSG_BEGIN = 3'd1,
      MSG_PASS  = 3'd2,
      MSG_FAIL  = 3'd3,
      MSG_END   = 3'd4
   } msg_t;

   // number of delay units for a difficulty setting: 00 -> 4 ... 11 -> 1
   function automatic logic [2:0] pace_units(input logic [1:0] sel);
      return 3'd4 - {1'b0, sel};
   endfunction

endpackage

// File: rtl/memseq_tick_timer.sv
module memseq_tick_timer #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] load_val,
   output logic         last
);

   logic [W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)             cnt_q <= '0;
      else if (load)          cnt_q <= load_val;
      else if (cnt_q != '0)   cnt_q <= cnt_q - W'(1);
   end

   assign last = (cnt_q == W'(1));

   // once drained, the counter stays at zero until reloaded (supports R3, R6)
   p_drained_stays_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (!load && cnt_q == '0) |=> (cnt_q == '0));

endmodule

// File: rtl/memseq_level.sv
module memseq_level #(
   parameter int MAX_LEVEL = 16,
   parameter int LW        = 5
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clr,
   input  logic          inc,
   output logic [LW-1:0] lvl_bin,
   output logic [3:0]    tens,
   output logic [3:0]    ones
);

   logic [LW-1:0] bin_q;
   logic [3:0]    ones_q;
   logic          wrap;

   assign wrap = (ones_q == 4'd9);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bin_q  <= LW'(1);
         ones_q <= 4'd1;
      end else if (clr) begin
         bin_q  <= LW'(1);
         ones_q <= 4'd1;
      end else if (inc) begin
         bin_q  <= bin_q + LW'(1);
         ones_q <= wrap ? 4'd0 : ones_q + 4'd1;
      end
   end

   generate
      if (MAX_LEVEL > 9) begin : g_two_digit
         logic [3:0] tens_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)            tens_q <= 4'd0;
            else if (clr)          tens_q <= 4'd0;
            else if (inc && wrap)  tens_q <= tens_q + 4'd1;
         end
         assign tens = tens_q;
      end else begin : g_one_digit
         assign tens = 4'd0;
      end
   endgenerate

   assign lvl_bin = bin_q;
   assign ones    = ones_q;

   p_level_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (bin_q != '0) && (bin_q <= LW'(MAX_LEVEL)));

   p_bcd_digit_r11: assert property (@(posedge clk) disable iff (!rst_n)
      ones_q <= 4'd9);

   p_bcd_tracks_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (int'(tens) * 10 + int'(ones_q)) == int'(bin_q));

endmodule

// File: rtl/memseq_blink.sv
module memseq_blink #(
   parameter int BLINK_TICKS = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic restart,
   output logic phase
);

   localparam int BW = $clog2(BLINK_TICKS + 1);

   logic [BW-1:0] cnt_q;
   logic          phase_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q   <= '0;
         phase_q <= 1'b1;
      end else if (restart) begin
         cnt_q   <= '0;
         phase_q <= 1'b1;
      end else if (cnt_q == BW'(BLINK_TICKS - 1)) begin
         cnt_q   <= '0;
         phase_q <= ~phase_q;
      end else begin
         cnt_q   <= cnt_q + BW'(1);
      end
   end

   assign phase = phase_q;

   p_phase_steady_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (!restart && cnt_q != BW'(BLINK_TICKS - 1)) |=> $stable(phase_q));

endmodule

// File: rtl/memseq_ctrl.sv
module memseq_ctrl
   import memseq_pkg::*;
#(
   parameter int MSG_TICKS   = 200_000_000,
   parameter int DELAY_UNIT  = 50_000_000,
   parameter int BLINK_TICKS = 50_000_000,
   parameter int HOLD_TICKS  = 200_000_000,
   parameter int MAX_LEVEL   = 16
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       ctr_btn,
   input  logic [3:0] dir_pulse,
   input  logic [1:0] diff_sw,
   input  logic       pat_ready,
   input  logic [1:0] pat_code,
   output logic       pat_reseed,
   output logic       pat_next,
   output logic [2:0] msg_code,
   output logic       msg_blink,
   output logic       msg_on,
   output logic [3:0] lvl_tens,
   output logic [3:0] lvl_ones,
   output logic       show_valid,
   output logic [1:0] show_pat
);

   localparam int DLY_MAX = 4 * DELAY_UNIT;
   localparam int T_MAX   = (MSG_TICKS > DLY_MAX) ? MSG_TICKS : DLY_MAX;
   localparam int TW      = $clog2(T_MAX + 1);
   localparam int HW      = $clog2(HOLD_TICKS + 1);
   localparam int LW      = $clog2(MAX_LEVEL + 1);

   generate
      if (MAX_LEVEL < 1 || MAX_LEVEL > 99) begin : g_bad_level
         $error("memseq_ctrl: MAX_LEVEL must lie in 1..99");
      end
      if (HOLD_TICKS < 2) begin : g_bad_hold
         $error("memseq_ctrl: HOLD_TICKS must be at least 2");
      end
      if (MSG_TICKS < 1 || DELAY_UNIT < 1 || BLINK_TICKS < 1) begin : g_bad_time
         $error("memseq_ctrl: time constants must be positive");
      end
   endgenerate

   game_st_t      st_q, st_d;
   logic          ctr_q;
   logic [HW-1:0] hold_q;
   logic [1:0]    diff_q;
   logic [LW-1:0] idx_q;
   logic [1:0]    exp_q;

   logic          start_edge, abort, seq_last, dir_any, dir_hit;
   logic [3:0]    want;
   logic          tmr_load, tmr_last;
   logic [TW-1:0] tmr_val, dly_ticks;
   logic          lvl_clr, lvl_inc;
   logic [LW-1:0] lvl_bin;
   msg_t          msg_sel;
   logic          blink_phase;

   assign start_edge = ctr_btn & ~ctr_q;
   assign abort      = ctr_btn && (hold_q == HW'(HOLD_TICKS - 1));
   assign seq_last   = ((idx_q + LW'(1)) == lvl_bin);
   assign want       = 4'b0001 << exp_q;
   assign dir_any    = |dir_pulse;
   assign dir_hit    = (dir_pulse == want);
   assign dly_ticks  = TW'(pace_units(diff_q)) * TW'(DELAY_UNIT);

   always_comb begin
      st_d       = st_q;
      tmr_load   = 1'b0;
      tmr_val    = '0;
      pat_reseed = 1'b0;
      pat_next   = 1'b0;
      lvl_clr    = 1'b0;
      lvl_inc    = 1'b0;
      case (st_q)
         ST_IDLE: if (start_edge) begin
            st_d    = ST_SEED_SHOW;
            lvl_clr = 1'b1;
         end
         ST_SEED_SHOW: begin
            pat_reseed = 1'b1;
            st_d       = ST_SHOW_FETCH;
         end
         ST_SHOW_FETCH: if (pat_ready) begin
            pat_next = 1'b1;
            tmr_load = 1'b1;
            tmr_val  = dly_ticks;
            st_d     = ST_SHOW_HOLD;
         end
         ST_SHOW_HOLD: if (tmr_last) begin
            st_d = seq_last ? ST_SEED_ENTRY : ST_SHOW_FETCH;
         end
         ST_SEED_ENTRY: begin
            pat_reseed = 1'b1;
            st_d       = ST_ENTRY_FETCH;
         end
         ST_ENTRY_FETCH: if (pat_ready) begin
            pat_next = 1'b1;
            st_d     = ST_ENTRY_GET;
         end
         ST_ENTRY_GET: if (dir_any) begin
            if (!dir_hit) begin
               st_d     = ST_FAIL;
               tmr_load = 1'b1;
               tmr_val  = TW'(MSG_TICKS);
            end else if (seq_last) begin
               st_d     = ST_PASS;
               tmr_load = 1'b1;
               tmr_val  = TW'(MSG_TICKS);
            end else begin
               st_d     = ST_ENTRY_FETCH;
            end
         end
         ST_PASS: if (tmr_last) begin
            if (lvl_bin == LW'(MAX_LEVEL)) begin
               st_d     = ST_OVER;
               tmr_load = 1'b1;
               tmr_val  = TW'(MSG_TICKS);
            end else begin
               st_d    = ST_SEED_SHOW;
               lvl_inc = 1'b1;
            end
         end
         ST_FAIL: if (tmr_last) begin
            st_d     = ST_OVER;
            tmr_load = 1'b1;
            tmr_val  = TW'(MSG_TICKS);
         end
         ST_OVER: if (tmr_last) st_d = ST_IDLE;
         default: st_d = ST_IDLE;
      endcase
      if (abort) begin
         st_d       = ST_IDLE;
         tmr_load   = 1'b0;
         pat_reseed = 1'b0;
         pat_next   = 1'b0;
         lvl_clr    = 1'b0;
         lvl_inc    = 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= ST_IDLE;
         ctr_q  <= 1'b0;
         hold_q <= '0;
         diff_q <= '0;
         idx_q  <= '0;
         exp_q  <= '0;
      end else begin
         st_q  <= st_d;
         ctr_q <= ctr_btn;
         if (!ctr_btn)                            hold_q <= '0;
         else if (hold_q != HW'(HOLD_TICKS - 1))  hold_q <= hold_q + HW'(1);
         if (st_q == ST_IDLE && start_edge)       diff_q <= diff_sw;
         case (st_q)
            ST_SEED_SHOW, ST_SEED_ENTRY: idx_q <= '0;
            ST_SHOW_FETCH, ST_ENTRY_FETCH: if (pat_ready) exp_q <= pat_code;
            ST_SHOW_HOLD: if (tmr_last && !seq_last) idx_q <= idx_q + LW'(1);
            ST_ENTRY_GET: if (dir_any && dir_hit && !seq_last) idx_q <= idx_q + LW'(1);
            default: ;
         endcase
      end
   end

   memseq_tick_timer #(.W(TW)) u_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (tmr_load),
      .load_val (tmr_val),
      .last     (tmr_last)
   );

   memseq_level #(.MAX_LEVEL(MAX_LEVEL), .LW(LW)) u_level (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr     (lvl_clr),
      .inc     (lvl_inc),
      .lvl_bin (lvl_bin),
      .tens    (lvl_tens),
      .ones    (lvl_ones)
   );

   memseq_blink #(.BLINK_TICKS(BLINK_TICKS)) u_blink (
      .clk     (clk),
      .rst_n   (rst_n),
      .restart (st_d != st_q),
      .phase   (blink_phase)
   );

   always_comb begin
      case (st_q)
         ST_IDLE: msg_sel = MSG_BEGIN;
         ST_PASS: msg_sel = MSG_PASS;
         ST_FAIL: msg_sel = MSG_FAIL;
         ST_OVER: msg_sel = MSG_END;
         default: msg_sel = MSG_NONE;
      endcase
   end

   assign msg_code   = msg_sel;
   assign msg_blink  = (msg_sel == MSG_BEGIN) || (msg_sel == MSG_END);
   assign msg_on     = msg_blink ? blink_phase : (msg_sel != MSG_NONE);
   assign show_valid = (st_q == ST_SHOW_HOLD);
   assign show_pat   = exp_q;

   p_one_handshake_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !(pat_reseed && pat_next));

   p_next_needs_ready_r4: assert property (@(posedge clk) disable iff (!rst_n)
      pat_next |-> pat_ready);

   p_long_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (ctr_btn && hold_q == HW'(HOLD_TICKS - 1)) |=> (st_q == ST_IDLE));

   p_fail_exit_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_FAIL) |=> (st_q == ST_FAIL || st_q == ST_OVER || st_q == ST_IDLE));

   p_diff_latched_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q != ST_IDLE && $past(st_q) != ST_IDLE) |-> $stable(diff_q));

   p_pass_from_entry_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_PASS && $past(st_q) != ST_PASS) |-> ($past(st_q) == ST_ENTRY_GET));

endmodule

// File: tb/memseq_ctrl_bench.sv
module memseq_ctrl_bench;

   localparam int CLK_PERIOD = 10;
   localparam int MSG   = 20;
   localparam int UNIT  = 3;
   localparam int BLINK = 4;
   localparam int HOLD  = 30;
   localparam int MAXL  = 11;

   // {diff_sw, expected hold cycles = (4 - sw) * UNIT}
   localparam logic [5:0] VEC [4] = '{
      {2'b00, 4'd12}, {2'b01, 4'd9}, {2'b10, 4'd6}, {2'b11, 4'd3}
   };

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       ctr_btn = 1'b0;
   logic [3:0] dir_pulse = 4'd0;
   logic [1:0] diff_sw = 2'd0;
   logic       pat_ready = 1'b1;
   logic [1:0] pat_code;
   logic       pat_reseed, pat_next, msg_blink, msg_on, show_valid;
   logic [2:0] msg_code;
   logic [3:0] lvl_tens, lvl_ones;
   logic [1:0] show_pat;

   int n_chk = 0;
   int n_bad = 0;

   always #(CLK_PERIOD / 2) clk = ~clk;

   memseq_ctrl #(
      .MSG_TICKS(MSG), .DELAY_UNIT(UNIT), .BLINK_TICKS(BLINK),
      .HOLD_TICKS(HOLD), .MAX_LEVEL(MAXL)
   ) u_memseq_ctrl (
      .clk(clk), .rst_n(rst_n), .ctr_btn(ctr_btn), .dir_pulse(dir_pulse),
      .diff_sw(diff_sw), .pat_ready(pat_ready), .pat_code(pat_code),
      .pat_reseed(pat_reseed), .pat_next(pat_next), .msg_code(msg_code),
      .msg_blink(msg_blink), .msg_on(msg_on), .lvl_tens(lvl_tens),
      .lvl_ones(lvl_ones), .show_valid(show_valid), .show_pat(show_pat)
   );

   function automatic logic [1:0] seq_fn(input int i);
      return 2'(i * 5 + i / 3 + 2);
   endfunction

   // pattern source model: reseed rewinds, next advances
   logic [5:0] gidx;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          gidx <= '0;
      else if (pat_reseed) gidx <= '0;
      else if (pat_next)   gidx <= gidx + 6'd1;
   end
   assign pat_code = seq_fn(int'(gidx));

   task automatic tick();
      @(negedge clk);
   endtask

   task automatic check_eq(input string tag, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
      end
   endtask

   task automatic press_start();
      ctr_btn = 1'b1;
      tick();
      tick();
      ctr_btn = 1'b0;
   endtask

   task automatic watch_show(input int dly, input int code, input string tag);
      int t = 0;
      int len = 0;
      int pat;
      while (!show_valid && t < 3000) begin tick(); t++; end
      pat = int'(show_pat);
      while (show_valid && len < 3000) begin len++; tick(); end
      check_eq({tag, " hold length"}, len, dly);
      check_eq({tag, " pattern"}, pat, code);
   endtask

   task automatic enter(input int code);
      repeat (5) tick();
      dir_pulse = 4'b0001 << code;
      tick();
      dir_pulse = 4'd0;
   endtask

   task automatic play_level(input int lvl, input int dly);
      int len = 0;
      check_eq("R11 level digits", int'(lvl_tens) * 10 + int'(lvl_ones), lvl);
      for (int i = 0; i < lvl; i++) watch_show(dly, int'(seq_fn(i)), "R3 R4 show");
      for (int i = 0; i < lvl; i++) enter(int'(seq_fn(i)));
      check_eq("R6 pass message", int'(msg_code), 2);
      while (msg_code == 3'd2 && len < 1000) begin len++; tick(); end
      check_eq("R6 pass duration", len, MSG);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog act=timeout exp=finished");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end

   initial begin
      int len;
      int seen;
      int wrong;

      // reset state and idle blinking
      repeat (3) tick();
      rst_n = 1'b1;
      check_eq("R1 begin code", int'(msg_code), 1);
      check_eq("R1 blink flag", int'(msg_blink), 1);
      check_eq("R1 lit", int'(msg_on), 1);
      check_eq("R1 level", int'(lvl_tens) * 10 + int'(lvl_ones), 1);
      check_eq("R1 no show", int'(show_valid), 0);
      repeat (3) tick();
      check_eq("R10 still lit", int'(msg_on), 1);
      tick();
      check_eq("R10 dark phase", int'(msg_on), 0);
      repeat (BLINK) tick();
      check_eq("R10 lit again", int'(msg_on), 1);

      // table: each difficulty, then abort by long hold
      for (int k = 0; k < 4; k++) begin
         diff_sw = VEC[k][5:4];
         press_start();
         check_eq("R2 level after start", int'(lvl_tens) * 10 + int'(lvl_ones), 1);
         check_eq("R2 message cleared", int'(msg_code), 0);
         watch_show(int'(VEC[k][3:0]), int'(seq_fn(0)), "R3 difficulty");
         ctr_btn = 1'b1;
         repeat (HOLD + 2) tick();
         ctr_btn = 1'b0;
         tick();
         check_eq("R9 long hold aborts", int'(msg_code), 1);
      end

      // stalled source, then full game at fastest pace
      pat_ready = 1'b0;
      diff_sw = 2'b11;
      press_start();
      seen = 0;
      repeat (20) begin
         tick();
         if (show_valid || pat_next) seen++;
      end
      check_eq("R4 stall blocks show", seen, 0);
      pat_ready = 1'b1;
      play_level(1, 3);
      diff_sw = 2'b00;  // must not affect the running game (R3)
      dir_pulse = 4'b1111;
      tick();
      dir_pulse = 4'd0;
      check_eq("R5 stray press ignored", int'(msg_code), 0);
      for (int l = 2; l <= MAXL; l++) play_level(l, 3);
      check_eq("R8 end after last level", int'(msg_code), 4);
      check_eq("R8 end blinks", int'(msg_blink), 1);
      len = 0;
      while (msg_code == 3'd4 && len < 1000) begin
         if (len == 0)     check_eq("R10 end starts lit", int'(msg_on), 1);
         if (len == BLINK) check_eq("R10 end dark", int'(msg_on), 0);
         len++;
         tick();
      end
      check_eq("R8 end duration", len, MSG);
      check_eq("R8 back to idle", int'(msg_code), 1);

      // failing game with a short hold that must be ignored
      diff_sw = 2'b10;
      press_start();
      watch_show(6, int'(seq_fn(0)), "R3 level1");
      ctr_btn = 1'b1;
      repeat (HOLD - 5) tick();
      ctr_btn = 1'b0;
      tick();
      check_eq("R9 short hold ignored", int'(msg_code), 0);
      enter(int'(seq_fn(0)));
      check_eq("R6 pass after hold", int'(msg_code), 2);
      len = 0;
      while (msg_code == 3'd2 && len < 1000) begin len++; tick(); end
      watch_show(6, int'(seq_fn(0)), "R3 level2 first");
      watch_show(6, int'(seq_fn(1)), "R3 level2 second");
      enter(int'(seq_fn(0)));
      wrong = int'(seq_fn(1) ^ 2'd1);
      enter(wrong);
      check_eq("R7 fail message", int'(msg_code), 3);
      check_eq("R7 fail steady", int'(msg_on), 1);
      len = 0;
      while (msg_code == 3'd3 && len < 1000) begin len++; tick(); end
      check_eq("R7 fail duration", len, MSG);
      check_eq("R7 game ends", int'(msg_code), 4);
      len = 0;
      while (msg_code == 3'd4 && len < 1000) begin len++; tick(); end
      check_eq("R8 end duration after fail", len, MSG);
      check_eq("R8 idle after fail", int'(msg_code), 1);

      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end

endmodule